// File: doc/BRIEF.md
# Mailbox and Doorbell Interrupt Hub

This block sits between a host-side register bus and a local-side register bus and gives the two sides a way to pass words and raise interrupts at each other. It holds eight 32-bit mailbox words that either side may write and read. It also holds two 32-bit doorbell words, one for each direction. In each doorbell, the sending side sets bits and the receiving side clears them.

A single control/status word holds the interrupt enables. When read, it also shows the live status flags: doorbell activity, the local interrupt input, the activity of each DMA channel, and one flag for each of the first four mailboxes. Two registered outputs combine the enabled sources. One is the host interrupt and the other is the local interrupt. Each DMA channel is sent to one of the two outputs by an input selector.

Both buses use the same address map. A cycle with `sel` high is an access, and `wr` selects write or read. Read data is combinational from the addressed register. Side effects, such as clearing a doorbell bit or a mailbox flag, take place at the clock edge that ends the access.

Top module: `mailbox_irq_hub`

## Requirements
- R1: Mailbox n (n = 0..7) is at byte address 0x40 + 4*n. Either bus can write a full 32-bit word there, and either bus reads back the last value written. All mailboxes read as zero after reset.
- R2: The host-to-local doorbell is at 0x60. A host write ORs the written data into it. A local write clears every bit written as 1. A host write of zero changes nothing. When a set and a clear of the same bit fall in the same cycle, the set wins.
- R3: The local-to-host doorbell is at 0x64. A local write ORs the written data into it, and a host write clears every bit written as 1.
- R4: The control/status word is at 0x68. Only bits 3, 8, 9, 11, 16, 17, 18 and 19 hold written values (write mask 0x000F0B08). The status bits are read-only: bit 13 = local-to-host doorbell nonzero, bit 15 = local interrupt input, bit 20 = host-to-local doorbell nonzero, bits 21/22 = DMA channel 0/1 active, bits 28+n = mailbox n flag.
- R5: A host write to mailbox n (n = 0..3) sets the flag at bit 28+n only while bit 3 is set. Host writes to mailboxes 4..7 never set a flag. Local writes to any mailbox never set a flag.
- R6: A local read of mailbox n clears its flag. A host read of that mailbox leaves the flag set.
- R7: host_irq equals bit 8 AND (bit 9 AND bit 13 status, OR bit 11 AND local input, OR any DMA channel c with enable bit 18+c, active, and routed to the host). It is registered, so it is due one clock edge after the state it reflects.
- R8: local_irq equals bit 16 AND (bit 17 AND bit 20 status, OR bit 3 AND any mailbox flag, OR any DMA channel c with enable bit 18+c, active, and routed to local). It is registered with the same one-edge delay.
- R9: When both buses write the same mailbox, or both write the control word, in the same cycle, the host data is kept.
- R10: After reset, both interrupt outputs and the control word read as zero while all inputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_sel | input | 1 | Host bus access strobe |
| h_wr | input | 1 | Host access is a write |
| h_addr | input | 8 | Host byte address |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data (combinational) |
| l_sel | input | 1 | Local bus access strobe |
| l_wr | input | 1 | Local access is a write |
| l_addr | input | 8 | Local byte address |
| l_wdata | input | 32 | Local write data |
| l_rdata | output | 32 | Local read data (combinational) |
| dma_active | input | 2 | Interrupt status of each DMA channel |
| dma_to_host | input | 2 | Per channel: 1 routes to host_irq, 0 routes to local_irq |
| local_irq_in | input | 1 | Local interrupt input |
| host_irq | output | 1 | Host-side interrupt output |
| local_irq | output | 1 | Local-side interrupt output |

## Verification
Read data is due in the same cycle as the address. Every register change, whether a write, a doorbell clear or a flag clear on a local read, is due at the edge that closes the access and can be seen by the next read. The interrupt outputs are due one further rising edge after the register state or input that drives them. The bench drives all inputs on the falling edge and samples read data shortly after driving. It samples the interrupt outputs only after one more full rising edge has passed, so every check lands in the cycle where its result is defined.

// File: rtl/mih_pkg.sv
package mih_pkg;
   // Address map (byte offsets)
   localparam int OFS_MBX = 'h40;
   localparam int OFS_H2L = 'h60;
   localparam int OFS_L2H = 'h64;
   localparam int OFS_CSR = 'h68;

   // Control/status bit positions
   localparam int B_MBX_EN   = 3;
   localparam int B_H_MASTER = 8;
   localparam int B_H_DB_EN  = 9;
   localparam int B_H_LIN_EN = 11;
   localparam int B_H_DB_ACT = 13;
   localparam int B_LIN_ACT  = 15;
   localparam int B_L_OUT_EN = 16;
   localparam int B_L_DB_EN  = 17;
   localparam int B_DMA_EN   = 18;
   localparam int B_L_DB_ACT = 20;
   localparam int B_DMA_ACT  = 21;
   localparam int B_FLAG     = 28;

   function automatic logic [31:0] csr_wmask(input int num_dma);
      logic [31:0] m;
      m = '0;
      m[B_MBX_EN]   = 1'b1;
      m[B_H_MASTER] = 1'b1;
      m[B_H_DB_EN]  = 1'b1;
      m[B_H_LIN_EN] = 1'b1;
      m[B_L_OUT_EN] = 1'b1;
      m[B_L_DB_EN]  = 1'b1;
      for (int c = 0; c < num_dma; c++) m[B_DMA_EN + c] = 1'b1;
      return m;
   endfunction
endpackage

// File: rtl/mih_doorbell.sv
module mih_doorbell #(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          set_en,
   input  logic [DW-1:0] set_bits,
   input  logic          clr_en,
   input  logic [DW-1:0] clr_bits,
   output logic [DW-1:0] bits_q,
   output logic          active
);
   logic [DW-1:0] set_v, clr_v;

   assign set_v  = set_en ? set_bits : '0;
   assign clr_v  = clr_en ? clr_bits : '0;
   assign active = |bits_q;

   // set has priority over a same-cycle clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bits_q <= '0;
      else        bits_q <= (bits_q & ~clr_v) | set_v;
   end
endmodule

// File: rtl/mih_mailbox_bank.sv
module mih_mailbox_bank #(
   parameter int DW       = 32,
   parameter int NUM_MBX  = 8,
   parameter int NUM_FLAG = 4,
   parameter int IDXW     = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  h_we,
   input  logic [IDXW-1:0]       h_idx,
   input  logic [DW-1:0]         h_wdata,
   input  logic                  l_we,
   input  logic                  l_rd,
   input  logic [IDXW-1:0]       l_idx,
   input  logic [DW-1:0]         l_wdata,
   input  logic                  flag_arm,
   output logic [NUM_MBX*DW-1:0] mbx_flat,
   output logic [NUM_FLAG-1:0]   flag_q
);
   genvar i;
   generate
      for (i = 0; i < NUM_MBX; i++) begin : g_mbx
         logic [DW-1:0] word_q;
         logic          h_hit, l_hit;
         assign h_hit = h_we && (h_idx == IDXW'(i));
         assign l_hit = l_we && (l_idx == IDXW'(i));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     word_q <= '0;
            else if (h_hit) word_q <= h_wdata;
            else if (l_hit) word_q <= l_wdata;
         end
         assign mbx_flat[i*DW +: DW] = word_q;

         if (i < NUM_FLAG) begin : g_flag
            logic set_f, clr_f;
            assign set_f = h_hit && flag_arm;
            assign clr_f = l_rd && (l_idx == IDXW'(i));
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) flag_q[i] <= 1'b0;
               else        flag_q[i] <= set_f | (flag_q[i] & ~clr_f);
            end
         end
      end
   endgenerate
endmodule

// File: rtl/mih_port_decode.sv
module mih_port_decode
   import mih_pkg::*;
#(
   parameter int DW      = 32,
   parameter int AW      = 8,
   parameter int NUM_MBX = 8,
   parameter int IDXW    = 3
) (
   input  logic [AW-1:0]         addr,
   input  logic [NUM_MBX*DW-1:0] mbx_flat,
   input  logic [DW-1:0]         h2l_q,
   input  logic [DW-1:0]         l2h_q,
   input  logic [DW-1:0]         csr_view,
   output logic                  mbx_hit,
   output logic [IDXW-1:0]       mbx_idx,
   output logic                  h2l_hit,
   output logic                  l2h_hit,
   output logic                  csr_hit,
   output logic [DW-1:0]         rdata
);
   localparam logic [AW-1:0] MBX_LO = AW'(OFS_MBX);
   localparam logic [AW-1:0] MBX_HI = AW'(OFS_MBX + 4 * NUM_MBX);
   logic [AW-1:0] rel;

   assign rel     = addr - MBX_LO;
   assign mbx_hit = (addr[1:0] == 2'b00) && (addr >= MBX_LO) && (addr < MBX_HI);
   assign mbx_idx = IDXW'(rel >> 2);
   assign h2l_hit = (addr == AW'(OFS_H2L));
   assign l2h_hit = (addr == AW'(OFS_L2H));
   assign csr_hit = (addr == AW'(OFS_CSR));

   always_comb begin
      rdata = '0;
      if (mbx_hit)      rdata = mbx_flat[mbx_idx*DW +: DW];
      else if (h2l_hit) rdata = h2l_q;
      else if (l2h_hit) rdata = l2h_q;
      else if (csr_hit) rdata = csr_view;
   end
endmodule

// File: rtl/mih_irq_combine.sv
module mih_irq_combine #(
   parameter int NUM_DMA  = 2,
   parameter int NUM_FLAG = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                h_master,
   input  logic                h_db_en,
   input  logic                h_db_act,
   input  logic                h_lin_en,
   input  logic                lin,
   input  logic                l_out_en,
   input  logic                l_db_en,
   input  logic                l_db_act,
   input  logic                mbx_en,
   input  logic [NUM_FLAG-1:0] flags,
   input  logic [NUM_DMA-1:0]  dma_en,
   input  logic [NUM_DMA-1:0]  dma_act,
   input  logic [NUM_DMA-1:0]  dma_to_host,
   output logic                host_irq,
   output logic                local_irq
);
   logic [NUM_DMA-1:0] dma_h, dma_l;
   logic               host_d, local_d;

   genvar c;
   generate
      for (c = 0; c < NUM_DMA; c++) begin : g_route
         assign dma_h[c] = dma_en[c] & dma_act[c] &  dma_to_host[c];
         assign dma_l[c] = dma_en[c] & dma_act[c] & ~dma_to_host[c];
      end
   endgenerate

   assign host_d  = h_master & ((h_db_en & h_db_act) | (h_lin_en & lin) | (|dma_h));
   assign local_d = l_out_en & ((l_db_en & l_db_act) | (mbx_en & (|flags)) | (|dma_l));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         host_irq  <= 1'b0;
         local_irq <= 1'b0;
      end else begin
         host_irq  <= host_d;
         local_irq <= local_d;
      end
   end
endmodule

// File: rtl/mailbox_irq_hub.sv
module mailbox_irq_hub
   import mih_pkg::*;
#(
   parameter int DW       = 32,
   parameter int AW       = 8,
   parameter int NUM_MBX  = 8,
   parameter int NUM_FLAG = 4,
   parameter int NUM_DMA  = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               h_sel,
   input  logic               h_wr,
   input  logic [AW-1:0]      h_addr,
   input  logic [DW-1:0]      h_wdata,
   output logic [DW-1:0]      h_rdata,
   input  logic               l_sel,
   input  logic               l_wr,
   input  logic [AW-1:0]      l_addr,
   input  logic [DW-1:0]      l_wdata,
   output logic [DW-1:0]      l_rdata,
   input  logic [NUM_DMA-1:0] dma_active,
   input  logic [NUM_DMA-1:0] dma_to_host,
   input  logic               local_irq_in,
   output logic               host_irq,
   output logic               local_irq
);
   localparam int IDXW = $clog2(NUM_MBX);
   localparam logic [DW-1:0] WMASK = DW'(csr_wmask(NUM_DMA));

   // elaboration-time parameter checks
   generate
      if (DW != 32)                          begin : g_bad_dw   $error("DW must be 32"); end
      if (NUM_MBX < 2 || NUM_MBX > 8)        begin : g_bad_mbx  $error("NUM_MBX out of 2..8"); end
      if (NUM_FLAG < 1 || NUM_FLAG > 4 || NUM_FLAG > NUM_MBX)
                                             begin : g_bad_flag $error("NUM_FLAG out of range"); end
      if (NUM_DMA < 1 || NUM_DMA > 2)        begin : g_bad_dma  $error("NUM_DMA out of 1..2"); end
      if (AW < 7)                            begin : g_bad_aw   $error("AW too narrow for map"); end
   endgenerate

   logic [NUM_MBX*DW-1:0] mbx_flat;
   logic [NUM_FLAG-1:0]   mbx_flag_q;
   logic [DW-1:0]         db_h2l_q, db_l2h_q, csr_q, csr_view;
   logic                  h2l_act, l2h_act;

   logic                  h_mbx_hit, h_h2l_hit, h_l2h_hit, h_csr_hit;
   logic                  l_mbx_hit, l_h2l_hit, l_l2h_hit, l_csr_hit;
   logic [IDXW-1:0]       h_idx, l_idx;
   logic                  h_we, l_we, l_re;

   assign h_we = h_sel & h_wr;
   assign l_we = l_sel & l_wr;
   assign l_re = l_sel & ~l_wr;

   mih_port_decode #(.DW(DW), .AW(AW), .NUM_MBX(NUM_MBX), .IDXW(IDXW)) u_hdec (
      .addr(h_addr), .mbx_flat(mbx_flat), .h2l_q(db_h2l_q), .l2h_q(db_l2h_q),
      .csr_view(csr_view), .mbx_hit(h_mbx_hit), .mbx_idx(h_idx),
      .h2l_hit(h_h2l_hit), .l2h_hit(h_l2h_hit), .csr_hit(h_csr_hit), .rdata(h_rdata));

   mih_port_decode #(.DW(DW), .AW(AW), .NUM_MBX(NUM_MBX), .IDXW(IDXW)) u_ldec (
      .addr(l_addr), .mbx_flat(mbx_flat), .h2l_q(db_h2l_q), .l2h_q(db_l2h_q),
      .csr_view(csr_view), .mbx_hit(l_mbx_hit), .mbx_idx(l_idx),
      .h2l_hit(l_h2l_hit), .l2h_hit(l_l2h_hit), .csr_hit(l_csr_hit), .rdata(l_rdata));

   mih_mailbox_bank #(.DW(DW), .NUM_MBX(NUM_MBX), .NUM_FLAG(NUM_FLAG), .IDXW(IDXW)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .h_we(h_we & h_mbx_hit), .h_idx(h_idx), .h_wdata(h_wdata),
      .l_we(l_we & l_mbx_hit), .l_rd(l_re & l_mbx_hit), .l_idx(l_idx), .l_wdata(l_wdata),
      .flag_arm(csr_q[B_MBX_EN]), .mbx_flat(mbx_flat), .flag_q(mbx_flag_q));

   // host rings local
   mih_doorbell #(.DW(DW)) u_db_h2l (
      .clk(clk), .rst_n(rst_n),
      .set_en(h_we & h_h2l_hit), .set_bits(h_wdata),
      .clr_en(l_we & l_h2l_hit), .clr_bits(l_wdata),
      .bits_q(db_h2l_q), .active(h2l_act));

   // local rings host
   mih_doorbell #(.DW(DW)) u_db_l2h (
      .clk(clk), .rst_n(rst_n),
      .set_en(l_we & l_l2h_hit), .set_bits(l_wdata),
      .clr_en(h_we & h_l2h_hit), .clr_bits(h_wdata),
      .bits_q(db_l2h_q), .active(l2h_act));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 csr_q <= '0;
      else if (h_we && h_csr_hit) csr_q <= h_wdata & WMASK;
      else if (l_we && l_csr_hit) csr_q <= l_wdata & WMASK;
   end

   always_comb begin
      csr_view                        = csr_q;
      csr_view[B_H_DB_ACT]            = l2h_act;
      csr_view[B_LIN_ACT]             = local_irq_in;
      csr_view[B_L_DB_ACT]            = h2l_act;
      csr_view[B_DMA_ACT +: NUM_DMA]  = dma_active;
      csr_view[B_FLAG +: NUM_FLAG]    = mbx_flag_q;
   end

   mih_irq_combine #(.NUM_DMA(NUM_DMA), .NUM_FLAG(NUM_FLAG)) u_irq (
      .clk(clk), .rst_n(rst_n),
      .h_master(csr_q[B_H_MASTER]), .h_db_en(csr_q[B_H_DB_EN]), .h_db_act(l2h_act),
      .h_lin_en(csr_q[B_H_LIN_EN]), .lin(local_irq_in),
      .l_out_en(csr_q[B_L_OUT_EN]), .l_db_en(csr_q[B_L_DB_EN]), .l_db_act(h2l_act),
      .mbx_en(csr_q[B_MBX_EN]), .flags(mbx_flag_q),
      .dma_en(csr_q[B_DMA_EN +: NUM_DMA]), .dma_act(dma_active), .dma_to_host(dma_to_host),
      .host_irq(host_irq), .local_irq(local_irq));
endmodule

// File: rtl/mailbox_irq_hub_chk.sv
module mailbox_irq_hub_chk
   import mih_pkg::*;
#(
   parameter int DW       = 32,
   parameter int AW       = 8,
   parameter int NUM_FLAG = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic                h_sel,
   input logic                h_wr,
   input logic [AW-1:0]       h_addr,
   input logic [DW-1:0]       h_rdata,
   input logic                l_sel,
   input logic                l_wr,
   input logic [AW-1:0]       l_addr,
   input logic                local_irq_in,
   input logic                host_irq,
   input logic                local_irq,
   input logic [DW-1:0]       csr_q,
   input logic [DW-1:0]       h2l_q,
   input logic [NUM_FLAG-1:0] flag_q
);
   // R2: without a local write to the doorbell, no set bit may drop
   assert_h2l_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(l_sel && l_wr && l_addr == AW'(OFS_H2L)) |=> ((h2l_q & $past(h2l_q)) == $past(h2l_q)));

   // R5: a mailbox flag only rises after a host write with the mailbox enable set
   assert_flag_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (|(flag_q & ~$past(flag_q))) |-> $past(h_sel && h_wr && csr_q[B_MBX_EN]));

   // R7: host output stays low while the master enable was clear
   assert_host_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(csr_q[B_H_MASTER]) |-> !host_irq);

   // R8: local output stays low while its output enable was clear
   assert_local_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(csr_q[B_L_OUT_EN]) |-> !local_irq);

   // R4: a host read of the control word shows the live local input
   assert_lin_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (h_sel && !h_wr && h_addr == AW'(OFS_CSR)) |-> (h_rdata[B_LIN_ACT] == local_irq_in));
endmodule

bind mailbox_irq_hub mailbox_irq_hub_chk #(.DW(DW), .AW(AW), .NUM_FLAG(NUM_FLAG)) u_chk (
   .clk(clk), .rst_n(rst_n), .h_sel(h_sel), .h_wr(h_wr), .h_addr(h_addr), .h_rdata(h_rdata),
   .l_sel(l_sel), .l_wr(l_wr), .l_addr(l_addr), .local_irq_in(local_irq_in),
   .host_irq(host_irq), .local_irq(local_irq), .csr_q(csr_q), .h2l_q(db_h2l_q),
   .flag_q(mbx_flag_q));

// File: tb/mailbox_irq_hub_tb.sv
`timescale 1ns/100ps
module mailbox_irq_hub_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        h_sel = 0, h_wr = 0, l_sel = 0, l_wr = 0;
   logic [7:0]  h_addr = 0, l_addr = 0;
   logic [31:0] h_wdata = 0, l_wdata = 0;
   logic [31:0] h_rdata, l_rdata;
   logic [1:0]  dma_active = 0, dma_to_host = 0;
   logic        local_irq_in = 0;
   logic        host_irq, local_irq;

   int vectors = 0;
   int fails   = 0;
   bit done    = 0;

   localparam logic [7:0]  A_H2L = 8'h60, A_L2H = 8'h64, A_CSR = 8'h68;
   localparam logic [31:0] WMASK = 32'h000F_0B08;

   always #2.5 clk = ~clk;

   mailbox_irq_hub u_dut (
      .clk(clk), .rst_n(rst_n),
      .h_sel(h_sel), .h_wr(h_wr), .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata),
      .l_sel(l_sel), .l_wr(l_wr), .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
      .dma_active(dma_active), .dma_to_host(dma_to_host), .local_irq_in(local_irq_in),
      .host_irq(host_irq), .local_irq(local_irq));

   function automatic logic [7:0] mb(input int n);
      return 8'(8'h40 + 4 * n);
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // all tasks start and end on a falling edge
   task automatic hw(input logic [7:0] a, input logic [31:0] d);
      h_sel = 1; h_wr = 1; h_addr = a; h_wdata = d;
      @(posedge clk); @(negedge clk);
      h_sel = 0; h_wr = 0;
   endtask

   task automatic lw(input logic [7:0] a, input logic [31:0] d);
      l_sel = 1; l_wr = 1; l_addr = a; l_wdata = d;
      @(posedge clk); @(negedge clk);
      l_sel = 0; l_wr = 0;
   endtask

   task automatic hr(input logic [7:0] a, output logic [31:0] d);
      h_sel = 1; h_wr = 0; h_addr = a;
      #1 d = h_rdata;
      @(posedge clk); @(negedge clk);
      h_sel = 0;
   endtask

   task automatic lr(input logic [7:0] a, output logic [31:0] d);
      l_sel = 1; l_wr = 0; l_addr = a;
      #1 d = l_rdata;
      @(posedge clk); @(negedge clk);
      l_sel = 0;
   endtask

   task automatic settle;
      @(posedge clk); @(negedge clk);
   endtask

   task automatic do_reset;
      rst_n = 0; dma_active = 0; dma_to_host = 0; local_irq_in = 0;
      repeat (2) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
   endtask

   task automatic t_reset;
      logic [31:0] d;
      do_reset();
      chk("R10 host_irq after reset", 32'(host_irq), 0);
      chk("R10 local_irq after reset", 32'(local_irq), 0);
      hr(A_CSR, d); chk("R10 control word after reset", d, 0);
      lr(mb(7), d); chk("R1 mailbox7 after reset", d, 0);
   endtask

   task automatic t_mailbox;
      logic [31:0] d;
      do_reset();
      for (int i = 0; i < 8; i++) hw(mb(i), 32'hA500_0000 | 32'(i * 32'h111));
      for (int i = 0; i < 8; i++) begin
         lr(mb(i), d); chk("R1 host write, local read", d, 32'hA500_0000 | 32'(i * 32'h111));
      end
      lw(mb(3), 32'hDEAD_BEEF);
      hr(mb(3), d); chk("R1 local write, host read", d, 32'hDEAD_BEEF);
   endtask

   task automatic t_csr;
      logic [31:0] d;
      do_reset();
      hw(A_CSR, 32'hFFFF_FFFF);
      lr(A_CSR, d); chk("R4 write mask", d, WMASK);
      local_irq_in = 1; dma_active = 2'b11;
      hr(A_CSR, d); chk("R4 live status bits 15/21/22", d, 32'h006F_8B08);
      local_irq_in = 0; dma_active = 0;
      lw(A_CSR, 32'h0);
      hr(A_CSR, d); chk("R4 cleared by local write", d, 0);
   endtask

   task automatic t_doorbells;
      logic [31:0] d;
      do_reset();
      hw(A_H2L, 32'hA5); hw(A_H2L, 32'h100);
      lr(A_H2L, d); chk("R2 host writes OR in", d, 32'h1A5);
      hr(A_CSR, d); chk("R4 bit20 active", 32'(d[20]), 1);
      lw(A_H2L, 32'h05);
      hr(A_H2L, d); chk("R2 local clears ones", d, 32'h1A0);
      hw(A_H2L, 32'h0);
      lr(A_H2L, d); chk("R2 host zero write no effect", d, 32'h1A0);
      lw(A_H2L, 32'h1A0);
      hr(A_CSR, d); chk("R4 bit20 inactive", 32'(d[20]), 0);
      lw(A_L2H, 32'h3);
      hr(A_CSR, d); chk("R4 bit13 active", 32'(d[13]), 1);
      hw(A_L2H, 32'h1);
      lr(A_L2H, d); chk("R3 host clears ones", d, 32'h2);
      lw(A_L2H, 32'h8);
      hr(A_L2H, d); chk("R3 local write ORs", d, 32'hA);
      hw(A_L2H, 32'hA);
      hr(A_CSR, d); chk("R3 cleared, bit13 low", 32'(d[13]), 0);
   endtask

   task automatic t_mbx_status;
      logic [31:0] d;
      do_reset();
      hw(mb(0), 32'h1);
      hr(A_CSR, d); chk("R5 no flag without enable", 32'(d[31:28]), 0);
      hw(A_CSR, 32'h8);
      hw(mb(2), 32'h2);
      hr(A_CSR, d); chk("R5 mailbox2 flag", 32'(d[31:28]), 32'h4);
      hw(mb(5), 32'h5); lw(mb(1), 32'h6);
      hr(A_CSR, d); chk("R5 mbx5 and local write set none", 32'(d[31:28]), 32'h4);
      hr(mb(2), d);
      hr(A_CSR, d); chk("R6 host read keeps flag", 32'(d[31:28]), 32'h4);
      lr(mb(2), d);
      hr(A_CSR, d); chk("R6 local read clears flag", 32'(d[31:28]), 32'h0);
      hw(mb(3), 32'h7); hw(mb(0), 32'h8);
      lr(A_CSR, d); chk("R5 mailbox0 and 3 flags", 32'(d[31:28]), 32'h9);
   endtask

   task automatic t_host_irq;
      do_reset();
      lw(A_L2H, 32'h1);
      hw(A_CSR, 32'h0000_0200); settle();
      chk("R7 master off", 32'(host_irq), 0);
      hw(A_CSR, 32'h0000_0300); settle();
      chk("R7 doorbell raises host", 32'(host_irq), 1);
      hw(A_L2H, 32'h1); settle();
      chk("R7 doorbell cleared", 32'(host_irq), 0);
      hw(A_CSR, 32'h0000_0900);
      local_irq_in = 1; settle();
      chk("R7 local input raises host", 32'(host_irq), 1);
      local_irq_in = 0; settle();
      chk("R7 local input dropped", 32'(host_irq), 0);
      dma_active = 2'b10; dma_to_host = 2'b10;
      hw(A_CSR, 32'h0008_0100); settle();
      chk("R7 dma1 routed to host", 32'(host_irq), 1);
      chk("R8 dma1 not on local", 32'(local_irq), 0);
      dma_to_host = 2'b00; settle();
      chk("R7 dma1 routed away", 32'(host_irq), 0);
   endtask

   task automatic t_local_irq;
      logic [31:0] d;
      do_reset();
      hw(A_H2L, 32'h10);
      lw(A_CSR, 32'h0002_0000); settle();
      chk("R8 output enable off", 32'(local_irq), 0);
      lw(A_CSR, 32'h0003_0000); settle();
      chk("R8 doorbell raises local", 32'(local_irq), 1);
      lw(A_H2L, 32'h10); settle();
      chk("R8 doorbell cleared", 32'(local_irq), 0);
      hw(A_CSR, 32'h0001_0008);
      hw(mb(1), 32'h55); settle();
      chk("R8 mailbox flag raises local", 32'(local_irq), 1);
      lr(mb(1), d); settle();
      chk("R8 flag read away", 32'(local_irq), 0);
      dma_active = 2'b01; dma_to_host = 2'b00;
      lw(A_CSR, 32'h0005_0000); settle();
      chk("R8 dma0 routed local", 32'(local_irq), 1);
      chk("R7 dma0 not on host", 32'(host_irq), 0);
   endtask

   task automatic t_collision;
      logic [31:0] d;
      do_reset();
      h_sel = 1; h_wr = 1; h_addr = mb(0); h_wdata = 32'h1111_1111;
      l_sel = 1; l_wr = 1; l_addr = mb(0); l_wdata = 32'h2222_2222;
      settle();
      h_addr = A_CSR; h_wdata = 32'h8; l_addr = A_CSR; l_wdata = 32'h100;
      settle();
      h_sel = 0; h_wr = 0; l_sel = 0; l_wr = 0;
      lr(mb(0), d); chk("R9 host wins mailbox", d, 32'h1111_1111);
      hr(A_CSR, d); chk("R9 host wins control word", d & WMASK, 32'h8);
      hw(A_H2L, 32'h1);
      h_sel = 1; h_wr = 1; h_addr = A_H2L; h_wdata = 32'h1;
      l_sel = 1; l_wr = 1; l_addr = A_H2L; l_wdata = 32'h1;
      settle();
      h_sel = 0; h_wr = 0; l_sel = 0; l_wr = 0;
      lr(A_H2L, d); chk("R2 set wins over clear", d, 32'h1);
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_mailbox();
      t_csr();
      t_doorbells();
      t_mbx_status();
      t_host_irq();
      t_local_irq();
      t_collision();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end
endmodule